// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire digital audio stream (bit clock, frame clock, serial data) into parallel sample words. It runs directly on the incoming bit clock and samples the frame clock and data on every rising bit-clock edge. A 3-bit format select picks one of five framings at run time, all on the same pins: left-justified, I2S, right-justified with 16 or 24 bits, or a time-division multiplexed frame of several fixed-width slots.

Each decoded word appears for one bit-clock cycle with a valid strobe and a slot index. In the stereo formats the index is 0 for the left channel and 1 for the right. In the multiplexed format it is the slot number. Stereo words are 24-bit values sign-extended to the output width. Multiplexed slots are passed through as raw words. Format codes that the block does not decode raise a flag and produce no words. A new format code is adopted only at a frame boundary, so the select input can be rewritten at any time without corrupting the stream.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is held and after its release, `sample_valid` is low and the active format is I2S (code 001). `fmt_unsupported` is low until a boundary adopts another code, whatever `fmt_sel` holds.
- R2: Code 000 (left-justified): frame clock high marks the left channel. The data MSB is the bit sampled on the first rising edge that sees the new frame-clock level. Up to 24 bits are taken MSB first into word bits 23 down to 0, with untransmitted low bits zero. The word is sign-extended from bit 23.
- R3: Code 001 (I2S): frame clock low marks the left channel. The MSB is sampled one bit clock later than in R2, and the word is otherwise packed as in R2. Every stereo word carries slot 0 for left and 1 for right.
- R4: Code 010: the word is the last 16 bits sampled before the frame-clock edge that ends the half, with the LSB last, sign-extended from bit 15. Frame clock high marks left.
- R5: Code 011: as R4 with the last 24 bits, sign-extended from bit 23.
- R6: Code 110: the frame clock is high for one bit clock to start a frame. The first bit of slot 0 follows on the next bit clock. Each slot is `SLOT_BITS` bits, MSB first, and is output unchanged with its slot number on the cycle after its last bit. Bits beyond `N_SLOTS` slots produce no word.
- R7: Codes 100, 101 and 111, once active, raise `fmt_unsupported` and produce no words.
- R8: `fmt_sel` is adopted only at a frame boundary: a frame-clock rise, or a fall while I2S is active. Words completed up to and including that boundary use the old format. The half (stereo) or frame (multiplexed) that begins at the boundary yields no word.
- R9: A stereo word is presented one bit clock after the rising edge that sees the frame-clock edge ending its half, and only if that half itself began at a frame-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Channel select (stereo) or frame pulse (multiplexed) |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Requested framing code |
| sample | output | SLOT_BITS | Decoded word |
| sample_valid | output | 1 | One-cycle strobe for `sample` |
| sample_slot | output | clog2(N_SLOTS) | Channel or slot index of `sample` |
| fmt_unsupported | output | 1 | Active format code is not decoded |

## Verification
The assertions assume each stereo half and each multiplexed slot lasts at least two bit clocks. This keeps words from ever arriving on back-to-back cycles. They also assume that `fmt_sel` and the frame clock change only between rising bit-clock edges. The stimulus drives all inputs on the falling edge and keeps every half at 16, 24 or 32 bit clocks. Each multiplexed frame is a one-cycle pulse followed by full slots, with extra trailing bits in one directed case. After reset, or after a format change, up to a few words from the settling frames are tolerated. The bench then requires the tail of the captured words to match the expected list exactly.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int N_SLOTS   = 8,
  parameter int SLOT_BITS = 32,
  localparam int SW       = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int AW       = $clog2(SLOT_BITS),
  localparam int TDM_BITS = N_SLOTS * SLOT_BITS,
  localparam int CW       = $clog2(TDM_BITS + SLOT_BITS + 2)
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 frame_clk,
  input  logic                 ser_data,
  input  logic [2:0]           fmt_sel,
  output logic [SLOT_BITS-1:0] sample,
  output logic                 sample_valid,
  output logic [SW-1:0]        sample_slot,
  output logic                 fmt_unsupported
);
  localparam logic [2:0] F_LJ = 3'd0, F_I2S = 3'd1, F_RJ16 = 3'd2, F_RJ24 = 3'd3, F_TDM = 3'd6;

  logic [2:0]           mode;
  logic                 fc_q, armed;
  logic [CW-1:0]        cnt, cnt_nx, k, dt;
  logic [SLOT_BITS-1:0] acc, acc_nx, word_nx;
  logic [23:0]          sh;
  logic                 is_tdm, is_i2s, supported, rise, fall, start, bnd, chg;
  logic                 tdm_last, left, emit;
  logic [SW-1:0]        slot_nx;
  int                   rel;

  assign is_tdm    = (mode == F_TDM);
  assign is_i2s    = (mode == F_I2S);
  assign supported = (mode == F_LJ) || is_i2s || (mode == F_RJ16) || (mode == F_RJ24) || is_tdm;
  assign fmt_unsupported = !supported;

  assign rise  = frame_clk & ~fc_q;
  assign fall  = ~frame_clk & fc_q;
  assign start = is_tdm ? rise : (rise | fall);
  assign bnd   = is_i2s ? fall : rise;
  assign chg   = bnd && (fmt_sel != mode);

  assign k      = start ? '0 : cnt;
  assign dt     = k - CW'(1);
  assign cnt_nx = start ? CW'(1) : ((&cnt) ? cnt : cnt + CW'(1));
  assign left   = is_i2s ? !fc_q : fc_q;

  always_comb begin
    acc_nx   = acc;
    tdm_last = 1'b0;
    rel      = int'(k) - (is_i2s ? 1 : 0);
    if (is_tdm) begin
      if (k != '0 && k <= CW'(TDM_BITS)) begin
        if (dt[AW-1:0] == '0) acc_nx = '0;
        acc_nx[AW'(SLOT_BITS-1) - dt[AW-1:0]] = ser_data;
        tdm_last = (dt[AW-1:0] == AW'(SLOT_BITS-1));
      end
    end else begin
      if (start) acc_nx = '0;
      if (rel >= 0 && rel < 24) acc_nx[AW'(23 - rel)] = ser_data;
    end
  end

  always_comb begin
    case (mode)
      F_RJ16:  word_nx = SLOT_BITS'($signed(sh[15:0]));
      F_RJ24:  word_nx = SLOT_BITS'($signed(sh[23:0]));
      F_TDM:   word_nx = acc_nx;
      default: word_nx = SLOT_BITS'($signed(acc[23:0]));
    endcase
  end

  assign emit    = armed && (is_tdm ? tdm_last : (start && supported));
  assign slot_nx = is_tdm ? SW'(dt >> AW) : (left ? SW'(0) : SW'(1));

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      mode         <= F_I2S;
      fc_q         <= 1'b0;
      armed        <= 1'b0;
      cnt          <= '0;
      acc          <= '0;
      sh           <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
      sample_slot  <= '0;
    end else begin
      fc_q         <= frame_clk;
      sh           <= {sh[22:0], ser_data};
      cnt          <= cnt_nx;
      acc          <= acc_nx;
      sample_valid <= emit;
      if (emit) begin
        sample      <= word_nx;
        sample_slot <= slot_nx;
      end
      if (chg) begin
        mode  <= fmt_sel;
        armed <= 1'b0;
      end else if (start) begin
        armed <= 1'b1;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == F_I2S) && !sample_valid);

  assert_stereo_sext_R2: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_valid && ($past(mode) != F_TDM) |->
      (sample[SLOT_BITS-1:23] == '0) || (sample[SLOT_BITS-1:23] == '1));

  assert_stereo_slot_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_valid && ($past(mode) != F_TDM) |-> sample_slot <= SW'(1));

  assert_rj16_sext_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_valid && ($past(mode) == F_RJ16) |->
      (sample[SLOT_BITS-1:15] == '0) || (sample[SLOT_BITS-1:15] == '1));

  assert_tdm_strobe_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_valid && ($past(mode) == F_TDM) |=> !sample_valid);

  assert_no_word_unsupported_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    fmt_unsupported && $past(fmt_unsupported) |-> !sample_valid);

  assert_mode_at_edge_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(frame_clk) != $past(fc_q)));
endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
  localparam int NS = 8;
  localparam int SB = 32;

  logic clk = 1'b0, rst_n = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [2:0] fmt = 3'b001;
  logic [SB-1:0] sample;
  logic sample_valid, fmt_unsupported;
  logic [2:0] sample_slot;

  always #10 clk = ~clk;

  audio_serial_rx #(.N_SLOTS(NS), .SLOT_BITS(SB)) i_audio_serial_rx (
    .bclk(clk), .rst_n(rst_n), .frame_clk(lrck), .ser_data(sdata), .fmt_sel(fmt),
    .sample(sample), .sample_valid(sample_valid), .sample_slot(sample_slot),
    .fmt_unsupported(fmt_unsupported));

  int errors = 0, checks = 0;
  logic [31:0] log_w [256];
  logic [2:0]  log_s [256];
  logic [31:0] exp_w [256];
  logic [2:0]  exp_s [256];
  int n_log = 0, n_exp = 0;

  always @(negedge clk)
    if (rst_n && sample_valid && n_log < 256) begin
      log_w[n_log] = sample;
      log_s[n_log] = sample_slot;
      n_log++;
    end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bitout(logic l, logic d);
    @(negedge clk);
    lrck = l;
    sdata = d;
  endtask

  task automatic clear_logs();
    @(posedge clk);
    n_log = 0;
    n_exp = 0;
  endtask

  task automatic push(logic [31:0] w, int s);
    if (n_exp < 256) begin
      exp_w[n_exp] = w;
      exp_s[n_exp] = 3'(s);
      n_exp++;
    end
  endtask

  function automatic logic [31:0] st_exp(int f, int h, logic [31:0] b);
    logic [23:0] v;
    v = '0;
    if (f == 2) begin
      for (int i = 0; i < 16; i++) v[15-i] = b[h-16+i];
      return 32'($signed(v[15:0]));
    end
    if (f == 3) begin
      for (int i = 0; i < 24; i++) v[23-i] = b[h-24+i];
    end else begin
      for (int i = 0; i < 24; i++) if (i + f < h) v[23-i] = b[i+f];
    end
    return 32'($signed(v));
  endfunction

  task automatic send_half(int f, logic lvl, int h, bit rec);
    logic [31:0] b;
    b = $urandom;
    for (int i = 0; i < h; i++) bitout(lvl, b[i]);
    if (rec) push(st_exp(f, h, b), (f == 1) ? int'(lvl) : int'(!lvl));
  endtask

  task automatic send_tdm(bit rec, int extra);
    bitout(1'b1, 1'($urandom));
    for (int s = 0; s < NS; s++) begin
      logic [31:0] w;
      w = $urandom;
      for (int i = 0; i < SB; i++) bitout(1'b0, w[31-i]);
      if (rec) push(w, s);
    end
    for (int i = 0; i < extra; i++) bitout(1'b0, 1'($urandom));
  endtask

  task automatic send_frame(int f, int h, bit rec, int extra);
    if (f == 6) send_tdm(rec, extra);
    else begin
      send_half(f, (f == 1) ? 1'b0 : 1'b1, h, rec);
      send_half(f, (f == 1) ? 1'b1 : 1'b0, h, rec);
    end
  endtask

  task automatic flush(int f);
    for (int i = 0; i < 6; i++) bitout((f == 1 || f == 6) ? 1'b0 : 1'b1, 1'b0);
  endtask

  task automatic compare(string req, int maxextra);
    int base;
    @(posedge clk);
    chk(n_log >= n_exp && n_log - n_exp <= maxextra, req, 32'(n_log), 32'(n_exp));
    if (n_log >= n_exp) begin
      base = n_log - n_exp;
      for (int i = 0; i < n_exp; i++) begin
        chk(log_w[base+i] == exp_w[i], req, log_w[base+i], exp_w[i]);
        chk(log_s[base+i] == exp_s[i], req, 32'(log_s[base+i]), 32'(exp_s[i]));
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) bitout(1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic seg(int f, int h, int nfr, int extra, string req);
    do_reset();
    fmt = 3'(f);
    clear_logs();
    send_frame(f, h, 1'b0, 0);
    for (int i = 0; i < nfr; i++) send_frame(f, h, 1'b1, extra);
    flush(f);
    compare(req, 2);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B));
    // R1: reset state while fmt_sel holds an undecoded code
    fmt = 3'b100;
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) bitout(1'b0, 1'b0);
    chk(!sample_valid, "R1 valid in reset", 32'(sample_valid), 0);
    chk(!fmt_unsupported, "R1 flag in reset", 32'(fmt_unsupported), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) bitout(1'b0, 1'b0);
    chk(!fmt_unsupported, "R1 default format after reset", 32'(fmt_unsupported), 0);
    chk(!sample_valid, "R1 valid after reset", 32'(sample_valid), 0);

    seg(0, 32, 3, 0, "R2 left-justified 32");
    seg(0, 16, 3, 0, "R2 left-justified short half");
    seg(1, 32, 3, 0, "R3 I2S 32");
    seg(1, 24, 3, 0, "R3 I2S 24");
    seg(2, 32, 3, 0, "R4 right-justified 16");
    seg(3, 32, 3, 0, "R5 right-justified 24");
    seg(3, 24, 3, 0, "R5 right-justified 24 tight");
    seg(6, 0, 2, 0, "R6 TDM");
    seg(6, 0, 2, 40, "R6 TDM trailing bits ignored");

    // R8/R9: change from left-justified to 24-bit right-justified mid-frame
    seg(0, 32, 1, 0, "R2 before change");
    clear_logs();
    send_half(0, 1'b0, 32, 1'b1);
    send_half(0, 1'b1, 32, 1'b1);
    fmt = 3'd3;
    send_half(0, 1'b0, 32, 1'b1);
    send_half(3, 1'b1, 32, 1'b0);
    send_half(3, 1'b0, 32, 1'b1);
    send_half(3, 1'b1, 32, 1'b1);
    send_half(3, 1'b0, 32, 1'b1);
    flush(3);
    compare("R8 format change at boundary", 2);

    // R7 and R8: undecoded code waits for a boundary, then silences output
    do_reset();
    clear_logs();
    fmt = 3'b101;
    for (int i = 0; i < 4; i++) bitout(1'b0, 1'b0);
    chk(!fmt_unsupported, "R8 no change before boundary", 32'(fmt_unsupported), 0);
    send_frame(0, 32, 1'b0, 0);
    send_frame(0, 32, 1'b0, 0);
    chk(fmt_unsupported, "R7 flag raised", 32'(fmt_unsupported), 1);
    clear_logs();
    for (int i = 0; i < 3; i++) send_frame(0, 32, 1'b0, 0);
    flush(0);
    @(posedge clk);
    chk(n_log == 0, "R7 no words while unsupported", 32'(n_log), 0);
    chk(fmt_unsupported, "R7 flag held", 32'(fmt_unsupported), 1);

    // random segments across all decoded formats
    for (int r = 0; r < 12; r++) begin
      int pick, f, h;
      pick = int'($urandom % 5);
      f = (pick == 4) ? 6 : pick;
      h = ($urandom % 2) ? 32 : 24;
      case (f)
        0: seg(f, h, 3, 0, "R2 random");
        1: seg(f, h, 3, 0, "R3 random");
        2: seg(f, h, 3, 0, "R4 random");
        3: seg(f, h, 3, 0, "R5 random");
        default: seg(f, h, 1, int'($urandom % 8), "R6 random");
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule